// File: doc/BRIEF.md
# Spline Wavelet ECG Band-Pass Prefilter

This block cleans a raw electrocardiogram sample stream before heart-beat analysis. It runs on a slow system clock. Once per sample period, a one-cycle strobe brings in a 12-bit unsigned converter code at 128 samples/s. The filter is a cascade of smoothing stages and one difference stage, spaced in the zero-inserted (à trous) manner. It uses only adds and arithmetic shifts. The result is a signed wavelet detail signal. At the default scale it peaks near 10–30 Hz. It rejects DC and slow baseline drift completely and strongly attenuates components near 50/60 Hz mains hum.

Each smoothing stage applies the quadratic spline kernel (1,3,3,1)/8. The taps of smoothing stage j (counting from 0) are spaced 2^j samples apart. The sum is formed as a plain add plus a doubled-and-added middle pair, then shifted right by 3. `LEVEL` selects the output scale: `LEVEL-1` smoothing stages are followed by a first difference with spacing 2^(LEVEL-1). Every delay line advances only on a sample strobe, so idle clock cycles between samples have no effect. After reset the delay lines are zero and the output strobe stays low until the window has filled.

Top module: `qswt_prefilter`

## Requirements
- R1: While reset is high and directly after it, `flt_vld` is 0 and `flt_data` is 0.
- R2: After reset, the first 2^(LEVEL+1)-3 strobed samples (13 at LEVEL=3) produce no output strobe. The next strobe and every later strobe each produce one.
- R3: `flt_vld` is a one-cycle pulse in the clock cycle after the `smp_vld` that caused it. Between pulses `flt_data` holds its value.
- R4: Each smoothing stage at spacing s outputs floor((x[n] + 3·x[n-s] + 3·x[n-2s] + x[n-3s]) / 8). Stage spacings are 1, 2, …, 2^(LEVEL-2).
- R5: The output is d[n] = y[n] − y[n−2^(LEVEL−1)], where y is the last smoothed signal. It is driven as 16-bit two's complement.
- R6: At LEVEL=3, after a zero history, one sample of code 512 followed by zeros yields exactly 8, 24, 48, 80, 88, 72, 32, −32, −72, −88, −80, −48, −24, −8, then 0.
- R7: A constant input (baseline) yields output 0 from the 14th sample after the input settles.
- R8: An input alternating between 0 and an even code A yields output 0 once the window holds only the alternating pattern.
- R9: For any 12-bit input, no internal sum overflows. Smoothed values stay in 0..4095 and the output stays in −4095..4095. A rising full-scale step gives only non-negative outputs, and a falling one only non-positive outputs.
- R10: Clock cycles without `smp_vld` do not advance the filter. The response to a sample sequence does not depend on the gaps between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow system clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | One-cycle strobe marking a new converter sample |
| smp_code | input | 12 | Unsigned converter code |
| flt_vld | output | 1 | One-cycle strobe marking a new filtered value |
| flt_data | output | 16 | Signed filtered value (two's complement) |

## Verification
The bench targets the exact impulse response, which exposes a wrong tap spacing, a wrong weight or a misplaced shift as a wrong value at a specific output index. It also targets the fill boundary: an off-by-one fill count shows up as a strobe one sample early or late. Gapped strobes check that idle cycles leave the delay lines in place. A design that shifted on every clock would smear the impulse response. Full-scale steps and the alternating pattern target overflow and the Nyquist null. A too-narrow accumulator would wrap to the wrong sign, and a wrong outer tap weight would leave a residual alternating output.

// File: rtl/qswt_pkg.sv
package qswt_pkg;

    localparam int ADC_W   = 12;
    localparam int DATA_W  = ADC_W + 4;
    localparam int MAX_CODE = (1 << ADC_W) - 1;

    typedef logic signed [DATA_W-1:0] sample_t;

    typedef struct packed {
        logic    vld;
        sample_t data;
    } flt_out_t;

    typedef enum logic {
        FILL_WAIT = 1'b0,
        FILL_DONE = 1'b1
    } fill_state_e;

    // number of input samples covered by the full filter window
    function automatic int window_span(input int level);
        return (1 << (level + 1)) - 2;
    endfunction

    function automatic int count_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/qswt_smooth_stage.sv
module qswt_smooth_stage
    import qswt_pkg::*;
#(
    parameter int SPACING = 1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  sample_t x,
    output sample_t y
);

    localparam int DEPTH = 3 * SPACING;

    sample_t line [DEPTH];
    sample_t mid_pair;
    sample_t acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) line[i] <= '0;
        end else if (en) begin
            line[0] <= x;
            for (int i = 1; i < DEPTH; i++) line[i] <= line[i-1];
        end
    end

    always_comb begin
        mid_pair = line[SPACING-1] + line[2*SPACING-1];
        acc      = x + line[3*SPACING-1] + (mid_pair <<< 1) + mid_pair;
        y        = acc >>> 3;
    end

    // R9
    acc_range_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (acc >= 0 && acc <= sample_t'(8 * MAX_CODE)));

    // R9
    smooth_range_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (y >= 0 && y <= sample_t'(MAX_CODE)));

endmodule

// File: rtl/qswt_detail_stage.sv
module qswt_detail_stage
    import qswt_pkg::*;
#(
    parameter int SPACING = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  sample_t x,
    output sample_t d
);

    sample_t line [SPACING];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SPACING; i++) line[i] <= '0;
        end else if (en) begin
            line[0] <= x;
            for (int i = 1; i < SPACING; i++) line[i] <= line[i-1];
        end
    end

    assign d = x - line[SPACING-1];

    // R9
    detail_range_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (d >= -sample_t'(MAX_CODE) && d <= sample_t'(MAX_CODE)));

endmodule

// File: rtl/qswt_fill_ctr.sv
module qswt_fill_ctr
    import qswt_pkg::*;
#(
    parameter int SPAN = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic filled
);

    localparam int CNT_W = count_width(SPAN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SPAN - 1);

    logic [CNT_W-1:0] cnt;
    fill_state_e      state;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            state <= FILL_WAIT;
        end else if (en && state == FILL_WAIT) begin
            cnt <= cnt + 1'b1;
            if (cnt + 1'b1 == LAST) state <= FILL_DONE;
        end
    end

    assign filled = (state == FILL_DONE);

    // R2
    fill_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R2
    fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
        filled |=> filled);

endmodule

// File: rtl/qswt_prefilter.sv
module qswt_prefilter
    import qswt_pkg::*;
#(
    parameter int LEVEL = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [ADC_W-1:0]  smp_code,
    output logic              flt_vld,
    output logic [DATA_W-1:0] flt_data
);

    localparam int SPAN       = window_span(LEVEL);
    localparam int DET_SPACE  = 1 << (LEVEL - 1);

    sample_t  chain [LEVEL];
    sample_t  detail;
    logic     filled;
    flt_out_t out_q;

    assign chain[0] = sample_t'({{(DATA_W-ADC_W){1'b0}}, smp_code});

    genvar j;
    generate
        for (j = 0; j < LEVEL - 1; j++) begin : g_smooth
            qswt_smooth_stage #(.SPACING(1 << j)) u_smooth (
                .clk (clk),
                .rst (rst),
                .en  (smp_vld),
                .x   (chain[j]),
                .y   (chain[j+1])
            );
        end
    endgenerate

    qswt_detail_stage #(.SPACING(DET_SPACE)) u_detail (
        .clk (clk),
        .rst (rst),
        .en  (smp_vld),
        .x   (chain[LEVEL-1]),
        .d   (detail)
    );

    qswt_fill_ctr #(.SPAN(SPAN)) u_fill (
        .clk    (clk),
        .rst    (rst),
        .en     (smp_vld),
        .filled (filled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.vld <= smp_vld && filled;
            if (smp_vld && filled) out_q.data <= detail;
        end
    end

    assign flt_vld  = out_q.vld;
    assign flt_data = out_q.data;

    // R3
    vld_latency_chk: assert property (@(posedge clk) disable iff (rst)
        flt_vld |-> $past(smp_vld));

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(smp_vld) |-> $stable(flt_data));

    // R2
    fill_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && !filled) |=> !flt_vld);

endmodule

// File: tb/qswt_prefilter_test.sv
`timescale 1ns/1ps
module qswt_prefilter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_vld = 1'b0;
    logic [11:0] smp_code = '0;
    logic        flt_vld;
    logic [15:0] flt_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam int FILL = 13;
    localparam int IMP [0:13] = '{8, 24, 48, 80, 88, 72, 32,
                                  -32, -72, -88, -80, -48, -24, -8};

    always #2.5 clk = ~clk;

    qswt_prefilter #(.LEVEL(3)) uut (
        .clk      (clk),
        .rst      (rst),
        .smp_vld  (smp_vld),
        .smp_code (smp_code),
        .flt_vld  (flt_vld),
        .flt_data (flt_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive one strobed sample, return the output seen one cycle later,
    // then idle for gap cycles checking the output stays put (R3, R10)
    task automatic push(input int code, input int gap, output bit v, output int d);
        @(negedge clk);
        smp_code = 12'(code);
        smp_vld  = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        v = flt_vld;
        d = int'($signed(flt_data));
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check(flt_vld == 1'b0, "R3 strobe width", int'(flt_vld), 0);
            check(int'($signed(flt_data)) == d, "R3 hold", int'($signed(flt_data)), d);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_vld = 1'b0;
        repeat (3) @(negedge clk);
        check(flt_vld == 1'b0, "R1 vld in reset", int'(flt_vld), 0);
        check(flt_data == 16'd0, "R1 data in reset", int'(flt_data), 0);
        rst = 1'b0;
        @(negedge clk);
        check(flt_vld == 1'b0, "R1 vld after reset", int'(flt_vld), 0);
        check(flt_data == 16'd0, "R1 data after reset", int'(flt_data), 0);
    endtask

    task automatic fill(input int code);
        bit v;
        int d;
        for (int i = 0; i < FILL; i++) begin
            push(code, 0, v, d);
            check(v == 1'b0, "R2 suppressed during fill", int'(v), 0);
        end
        push(code, 0, v, d);
        check(v == 1'b1, "R2 first strobe after fill", int'(v), 1);
        check(d == 0, "R7 steady fill value", d, 0);
    endtask

    // walk the impulse table with a given gap between strobes
    task automatic impulse_walk(input int gap, input string tag);
        bit v;
        int d;
        for (int i = 0; i < 20; i++) begin
            push((i == 0) ? 512 : 0, gap, v, d);
            check(v == 1'b1, {tag, " strobe"}, int'(v), 1);
            check(d == ((i < 14) ? IMP[i] : 0), tag, d, (i < 14) ? IMP[i] : 0);
        end
    endtask

    initial begin
        bit v;
        int d;
        do_reset();                     // R1
        fill(0);                        // R2

        impulse_walk(0, "R6 R4 R5 impulse");
        impulse_walk(4, "R10 gapped impulse");

        // R9 rising full-scale step, then R7 baseline
        for (int i = 0; i < 20; i++) begin
            push(4095, (i % 3), v, d);
            check(d >= 0 && d <= 4095, "R9 rising step range", d, 0);
            if (i >= 13) check(d == 0, "R7 constant input", d, 0);
        end
        // R9 falling full-scale step
        for (int i = 0; i < 20; i++) begin
            push(0, 0, v, d);
            check(d <= 0 && d >= -4095, "R9 falling step range", d, 0);
            if (i >= 13) check(d == 0, "R7 settle to zero", d, 0);
        end

        // R8 alternating pattern
        for (int i = 0; i < 30; i++) begin
            push((i % 2 == 0) ? 4094 : 0, 0, v, d);
            if (i >= 13) check(d == 0, "R8 alternating null", d, 0);
        end

        // R1 R2 reset mid-stream, refill at another level
        do_reset();
        fill(1000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule